// File: doc/BRIEF.md
# DRAM Controller Operating-State Sequencer

This block holds the top-level operating state of a DRAM controller. Software writes a command code into a state-control port and reads the current state, together with the cause of the last low-power entry, from a status word. The sequencer moves between memory initialisation, configuration, access and low-power. Each move to configuration, access, low-power or back from low-power first enters a visible request state. It stays there until the rest of the controller acknowledges the move.

Low-power entry starts in one of two ways. Software issues a sleep command, or an idle request from hardware arrives while hardware entry is enabled. A software-started low-power period ends only with a wake-up command. A hardware-started one ends when the hardware idle request drops, and software cannot cut it short. Every exit from low-power passes through the exit request and lands in access. DRAM command timing is left to the rest of the controller.

Top module: `dram_opstate_seq`

## Requirements
- R1: After synchronous reset the status word is 0x00 (state init-memory, trigger 0) and all four request outputs are low.
- R2: Status bits 2:0 carry the state: 0 init-memory, 1 config, 2 config-request, 3 access, 4 access-request, 5 low-power, 6 low-power-entry-request, 7 low-power-exit-request. Bits 6:4 carry the low-power trigger. Bits 3 and 7 read 0. Command codes are 0 init, 1 config, 2 go, 3 sleep, 4 wakeup.
- R3: A config command in init-memory or access moves the state to config-request on the next edge. The state stays there, with cfg_req high, until cfg_ack is seen, and then moves to config.
- R4: A go command in config moves the state to access-request. The state stays there, with acc_req high, until acc_ack is seen, and then moves to access.
- R5: An init command in config returns the state to init-memory on the next edge.
- R6: A sleep command in access moves the state to low-power-entry-request with trigger 2. The state stays there, with lpe_req high, until lpe_ack is seen, and then moves to low-power.
- R7: In access, with hw_lp_en high, hw_lp_req high and no legal command that cycle, the state moves to low-power-entry-request with trigger 1. With hw_lp_en low, hw_lp_req has no effect. A legal config or sleep command in the same cycle takes precedence.
- R8: In low-power with trigger 2, a wakeup command moves the state to low-power-exit-request. The state stays there, with lpx_req high, until lpx_ack is seen, and then moves to access with the trigger cleared to 0. No command leads from low-power to config.
- R9: In low-power with trigger 1, wakeup commands are ignored. The state moves to low-power-exit-request when hw_lp_req is low.
- R10: A command that is not legal in the current state is ignored and leaves the status unchanged. This covers codes 5 to 7 and any command in a request state.
- R11: An acknowledge outside its own request state has no effect. Each request output is high exactly while the state is its request state, so at most one is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | State-control command strobe |
| cmd_code | input | 3 | State-control command code |
| hw_lp_en | input | 1 | Enables hardware-started low-power entry |
| hw_lp_req | input | 1 | Hardware idle request |
| cfg_ack | input | 1 | Acknowledge of config-request |
| acc_ack | input | 1 | Acknowledge of access-request |
| lpe_ack | input | 1 | Acknowledge of low-power entry (self-refresh/power-down done) |
| lpx_ack | input | 1 | Acknowledge of low-power exit |
| status | output | 8 | State in bits 2:0, low-power trigger in bits 6:4 |
| cfg_req | output | 1 | Config-request toward the controller |
| acc_req | output | 1 | Access-request toward the controller |
| lpe_req | output | 1 | Low-power entry request |
| lpx_req | output | 1 | Low-power exit request |

## Verification
A wrong state register shows on the status port one edge after the offending command or acknowledge. It also shows on the request outputs in the same cycle, because both come straight from registers. A fault in the trigger record stays hidden until the next low-power period. It then shows in bits 6:4, or as a wakeup command that is wrongly accepted or wrongly refused. The bench therefore follows every cycle against an independent model of the transitions, under random commands, acknowledges and idle requests, so such a latent error appears at the first low-power period after the fault.

// File: rtl/dram_opstate_pkg.sv
package dram_opstate_pkg;

  typedef enum logic [2:0] {
    ST_INIT    = 3'd0,
    ST_CFG     = 3'd1,
    ST_CFG_REQ = 3'd2,
    ST_ACC     = 3'd3,
    ST_ACC_REQ = 3'd4,
    ST_LP      = 3'd5,
    ST_LPE_REQ = 3'd6,
    ST_LPX_REQ = 3'd7
  } opstate_e;

  localparam logic [2:0] CMD_INIT  = 3'd0;
  localparam logic [2:0] CMD_CFG   = 3'd1;
  localparam logic [2:0] CMD_GO    = 3'd2;
  localparam logic [2:0] CMD_SLEEP = 3'd3;
  localparam logic [2:0] CMD_WAKE  = 3'd4;

  localparam int unsigned TRIG_W = 3;
  localparam logic [TRIG_W-1:0] TRIG_NONE = 3'd0;
  localparam logic [TRIG_W-1:0] TRIG_HW   = 3'd1;
  localparam logic [TRIG_W-1:0] TRIG_SW   = 3'd2;

  typedef struct packed {
    logic to_cfg;
    logic to_acc;
    logic to_init;
    logic sw_sleep;
    logic hw_sleep;
    logic wake;
  } opevent_t;

endpackage

// File: rtl/dram_opstate_filter.sv
module dram_opstate_filter
  import dram_opstate_pkg::*;
#(
  parameter int unsigned CMD_W = 3
) (
  input  opstate_e          state,
  input  logic [TRIG_W-1:0] trig,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              hw_lp_en,
  input  logic              hw_lp_req,
  output opevent_t          ev
);

  logic is_cfg, is_go, is_init, is_sleep, is_wake;

  always_comb begin
    is_cfg   = cmd_valid && (cmd_code == CMD_W'(CMD_CFG));
    is_go    = cmd_valid && (cmd_code == CMD_W'(CMD_GO));
    is_init  = cmd_valid && (cmd_code == CMD_W'(CMD_INIT));
    is_sleep = cmd_valid && (cmd_code == CMD_W'(CMD_SLEEP));
    is_wake  = cmd_valid && (cmd_code == CMD_W'(CMD_WAKE));

    ev          = '0;
    ev.to_cfg   = is_cfg && (state == ST_INIT || state == ST_ACC);
    ev.to_acc   = is_go && (state == ST_CFG);
    ev.to_init  = is_init && (state == ST_CFG);
    ev.sw_sleep = is_sleep && (state == ST_ACC);
    // a legal software command in the same cycle wins over hardware entry
    ev.hw_sleep = (state == ST_ACC) && hw_lp_en && hw_lp_req
                  && !is_cfg && !is_sleep;
    // hardware-started low power is left only by the hardware itself
    ev.wake     = (state == ST_LP) &&
                  ((trig == TRIG_HW) ? !hw_lp_req : is_wake);
  end

endmodule

// File: rtl/dram_opstate_core.sv
module dram_opstate_core
  import dram_opstate_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  opevent_t ev,
  input  logic     cfg_ack,
  input  logic     acc_ack,
  input  logic     lpe_ack,
  input  logic     lpx_ack,
  output opstate_e state,
  output logic     exit_done,
  output logic     cfg_req,
  output logic     acc_req,
  output logic     lpe_req,
  output logic     lpx_req
);

  opstate_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_INIT:    if (ev.to_cfg) state_d = ST_CFG_REQ;
      ST_CFG_REQ: if (cfg_ack) state_d = ST_CFG;
      ST_CFG: begin
        if (ev.to_acc)       state_d = ST_ACC_REQ;
        else if (ev.to_init) state_d = ST_INIT;
      end
      ST_ACC_REQ: if (acc_ack) state_d = ST_ACC;
      ST_ACC: begin
        if (ev.to_cfg)                       state_d = ST_CFG_REQ;
        else if (ev.sw_sleep || ev.hw_sleep) state_d = ST_LPE_REQ;
      end
      ST_LPE_REQ: if (lpe_ack) state_d = ST_LP;
      ST_LP:      if (ev.wake) state_d = ST_LPX_REQ;
      ST_LPX_REQ: if (lpx_ack) state_d = ST_ACC;
      default:    state_d = ST_INIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_INIT;
      cfg_req <= 1'b0;
      acc_req <= 1'b0;
      lpe_req <= 1'b0;
      lpx_req <= 1'b0;
    end else begin
      state_q <= state_d;
      cfg_req <= (state_d == ST_CFG_REQ);
      acc_req <= (state_d == ST_ACC_REQ);
      lpe_req <= (state_d == ST_LPE_REQ);
      lpx_req <= (state_d == ST_LPX_REQ);
    end
  end

  assign state     = state_q;
  assign exit_done = (state_q == ST_LPX_REQ) && lpx_ack;

  assert_cfg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_CFG_REQ && !cfg_ack) |=> (state_q == ST_CFG_REQ));

  assert_acc_source_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ACC && $past(state_q) != ST_ACC) |->
      ($past(state_q) == ST_ACC_REQ || $past(state_q) == ST_LPX_REQ));

  assert_lpe_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LPE_REQ && !lpe_ack) |=> (state_q == ST_LPE_REQ));

  assert_lp_no_cfg_R8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_LP) |=> (state_q == ST_LP || state_q == ST_LPX_REQ));

  assert_req_onehot_R11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_req, acc_req, lpe_req, lpx_req}));

  assert_req_match_R11: assert property (@(posedge clk) disable iff (rst)
    lpx_req |-> (state_q == ST_LPX_REQ));

endmodule

// File: rtl/dram_opstate_trig.sv
module dram_opstate_trig
  import dram_opstate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  opevent_t          ev,
  input  logic              exit_done,
  output logic [TRIG_W-1:0] trig
);

  always_ff @(posedge clk) begin
    if (rst)              trig <= TRIG_NONE;
    else if (ev.sw_sleep) trig <= TRIG_SW;
    else if (ev.hw_sleep) trig <= TRIG_HW;
    else if (exit_done)   trig <= TRIG_NONE;
  end

  assert_trig_stable_R6: assert property (@(posedge clk) disable iff (rst)
    (trig != TRIG_NONE && !exit_done) |=> $stable(trig));

endmodule

// File: rtl/dram_opstate_seq.sv
module dram_opstate_seq
  import dram_opstate_pkg::*;
#(
  parameter int unsigned CMD_W    = 3,
  parameter int unsigned STAT_W   = 8,
  parameter int unsigned TRIG_LSB = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              hw_lp_en,
  input  logic              hw_lp_req,
  input  logic              cfg_ack,
  input  logic              acc_ack,
  input  logic              lpe_ack,
  input  logic              lpx_ack,
  output logic [STAT_W-1:0] status,
  output logic              cfg_req,
  output logic              acc_req,
  output logic              lpe_req,
  output logic              lpx_req
);

  localparam int unsigned STATE_W = $bits(opstate_e);

  opstate_e          state;
  logic [TRIG_W-1:0] trig;
  opevent_t          ev;
  logic              exit_done;

  dram_opstate_filter #(.CMD_W(CMD_W)) filter_i (
    .state     (state),
    .trig      (trig),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .hw_lp_en  (hw_lp_en),
    .hw_lp_req (hw_lp_req),
    .ev        (ev)
  );

  dram_opstate_core core_i (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .cfg_ack   (cfg_ack),
    .acc_ack   (acc_ack),
    .lpe_ack   (lpe_ack),
    .lpx_ack   (lpx_ack),
    .state     (state),
    .exit_done (exit_done),
    .cfg_req   (cfg_req),
    .acc_req   (acc_req),
    .lpe_req   (lpe_req),
    .lpx_req   (lpx_req)
  );

  dram_opstate_trig trig_i (
    .clk       (clk),
    .rst       (rst),
    .ev        (ev),
    .exit_done (exit_done),
    .trig      (trig)
  );

  always_comb begin
    status                        = '0;
    status[STATE_W-1:0]           = state;
    status[TRIG_LSB +: TRIG_W]    = trig;
  end

  assert_trig_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_INIT || state == ST_CFG || state == ST_CFG_REQ ||
     state == ST_ACC || state == ST_ACC_REQ) |-> (trig == TRIG_NONE));

  assert_hw_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LP && trig == TRIG_HW && hw_lp_req) |=> (state == ST_LP));

  assert_hw_off_R7: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACC && !hw_lp_en && !cmd_valid) |=> (state == ST_ACC));

endmodule

// File: tb/dram_opstate_seq_tb_top.sv
module dram_opstate_seq_tb_top;

  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic       cmd_valid, hw_lp_en, hw_lp_req;
  logic [2:0] cmd_code;
  logic       cfg_ack, acc_ack, lpe_ack, lpx_ack;
  logic [7:0] status;
  logic       cfg_req, acc_req, lpe_req, lpx_req;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  logic [2:0] m_st, m_tr;

  always #(CLK_P/2) clk = ~clk;

  dram_opstate_seq dut_i (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .hw_lp_en(hw_lp_en), .hw_lp_req(hw_lp_req),
    .cfg_ack(cfg_ack), .acc_ack(acc_ack), .lpe_ack(lpe_ack), .lpx_ack(lpx_ack),
    .status(status), .cfg_req(cfg_req), .acc_req(acc_req),
    .lpe_req(lpe_req), .lpx_req(lpx_req)
  );

  function automatic logic [5:0] model_next(
    input logic [2:0] s, input logic [2:0] t, input logic cv,
    input logic [2:0] cc, input logic ca, input logic aa,
    input logic ea, input logic xa, input logic he, input logic hr);
    logic [2:0] ns, nt;
    ns = s; nt = t;
    case (s)
      3'd0: if (cv && cc == 3'd1) ns = 3'd2;
      3'd2: if (ca) ns = 3'd1;
      3'd1: if (cv && cc == 3'd2) ns = 3'd4;
            else if (cv && cc == 3'd0) ns = 3'd0;
      3'd4: if (aa) ns = 3'd3;
      3'd3: if (cv && cc == 3'd1) ns = 3'd2;
            else if (cv && cc == 3'd3) begin ns = 3'd6; nt = 3'd2; end
            else if (he && hr) begin ns = 3'd6; nt = 3'd1; end
      3'd6: if (ea) ns = 3'd5;
      3'd5: if (t == 3'd1) begin if (!hr) ns = 3'd7; end
            else if (cv && cc == 3'd4) ns = 3'd7;
      3'd7: if (xa) begin ns = 3'd3; nt = 3'd0; end
      default: ns = 3'd0;
    endcase
    return {nt, ns};
  endfunction

  task automatic check_val(input string tag, input logic [31:0] act,
                           input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic cv, input logic [2:0] cc, input logic ca,
                       input logic aa, input logic ea, input logic xa,
                       input logic he, input logic hr);
    cmd_valid = cv; cmd_code = cc; cfg_ack = ca; acc_ack = aa;
    lpe_ack = ea; lpx_ack = xa; hw_lp_en = he; hw_lp_req = hr;
  endtask

  // one clock edge, model update and full port comparison
  task automatic tick(input string tag);
    logic [5:0] nx;
    logic [3:0] rq;
    nx = model_next(m_st, m_tr, cmd_valid, cmd_code, cfg_ack, acc_ack,
                    lpe_ack, lpx_ack, hw_lp_en, hw_lp_req);
    @(posedge clk);
    #1;
    m_st = nx[2:0];
    m_tr = nx[5:3];
    rq = {m_st == 3'd2, m_st == 3'd4, m_st == 3'd6, m_st == 3'd7};
    check_val(tag, {24'd0, status}, {24'd0, 1'b0, m_tr, 1'b0, m_st});
    check_val(tag, {28'd0, cfg_req, acc_req, lpe_req, lpx_req}, {28'd0, rq});
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic hr_r;
    void'($urandom(32'd20250611));
    rst = 1'b1;
    drive(0, 3'd0, 0, 0, 0, 0, 0, 0);
    m_st = 3'd0; m_tr = 3'd0;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    check_val("R1 status", {24'd0, status}, 32'h00);
    check_val("R1 requests", {28'd0, cfg_req, acc_req, lpe_req, lpx_req}, 32'h0);

    drive(1, 3'd2, 0, 0, 0, 0, 0, 0); tick("R10 go in init");
    check_val("R10 go in init", {24'd0, status}, 32'h00);
    drive(0, 3'd0, 1, 1, 1, 1, 0, 0); tick("R11 stray acks");
    check_val("R11 stray acks", {24'd0, status}, 32'h00);
    drive(1, 3'd1, 0, 0, 0, 0, 0, 0); tick("R3 config from init");
    check_val("R3 config-request", {24'd0, status}, 32'h02);
    check_val("R3 cfg_req", {31'd0, cfg_req}, 32'h1);
    drive(1, 3'd2, 0, 1, 0, 0, 0, 0); tick("R3 hold without ack");
    drive(1, 3'd0, 0, 0, 0, 0, 0, 0); tick("R10 command in request state");
    check_val("R3 still waiting", {24'd0, status}, 32'h02);
    drive(0, 3'd0, 1, 0, 0, 0, 0, 0); tick("R3 ack");
    check_val("R3 config", {24'd0, status}, 32'h01);
    drive(1, 3'd0, 0, 0, 0, 0, 0, 0); tick("R5 init from config");
    check_val("R5 init", {24'd0, status}, 32'h00);
    drive(1, 3'd1, 0, 0, 0, 0, 0, 0); tick("R3 config again");
    drive(0, 3'd0, 1, 0, 0, 0, 0, 0); tick("R3 ack again");
    drive(1, 3'd2, 0, 0, 0, 0, 0, 0); tick("R4 go");
    check_val("R4 access-request", {24'd0, status}, 32'h04);
    drive(0, 3'd0, 0, 0, 0, 0, 0, 0); tick("R4 hold");
    drive(0, 3'd0, 0, 1, 0, 0, 0, 0); tick("R4 ack");
    check_val("R4 access", {24'd0, status}, 32'h03);
    drive(0, 3'd0, 0, 0, 0, 0, 0, 1); tick("R7 disabled");
    check_val("R7 disabled", {24'd0, status}, 32'h03);
    drive(1, 3'd1, 0, 0, 0, 0, 1, 1); tick("R7 command wins");
    check_val("R7 command wins", {24'd0, status}, 32'h02);
    drive(0, 3'd0, 1, 0, 0, 0, 1, 1); tick("R3 ack");
    drive(1, 3'd2, 0, 0, 0, 0, 1, 0); tick("R4 go");
    drive(0, 3'd0, 0, 1, 0, 0, 1, 0); tick("R4 ack");
    drive(1, 3'd2, 0, 0, 0, 0, 1, 1); tick("R7 hw entry with illegal cmd");
    check_val("R7 hw entry", {24'd0, status}, 32'h16);
    drive(0, 3'd0, 0, 0, 1, 0, 1, 1); tick("R6 entry ack");
    check_val("R7 low-power hw", {24'd0, status}, 32'h15);
    drive(1, 3'd4, 0, 0, 0, 0, 1, 1); tick("R9 wakeup ignored");
    check_val("R9 wakeup ignored", {24'd0, status}, 32'h15);
    drive(0, 3'd0, 0, 0, 0, 0, 1, 0); tick("R9 hw exit");
    check_val("R9 exit request", {24'd0, status}, 32'h17);
    drive(0, 3'd0, 0, 0, 0, 1, 1, 0); tick("R8 exit ack");
    check_val("R8 trigger cleared", {24'd0, status}, 32'h03);
    drive(1, 3'd3, 0, 0, 0, 0, 0, 0); tick("R6 sleep");
    check_val("R6 sleep request", {24'd0, status}, 32'h26);
    drive(0, 3'd0, 0, 0, 0, 0, 0, 0); tick("R6 hold");
    drive(0, 3'd0, 0, 0, 1, 0, 0, 0); tick("R6 ack");
    check_val("R6 low-power sw", {24'd0, status}, 32'h25);
    drive(1, 3'd1, 0, 0, 0, 0, 0, 0); tick("R8 no config from low-power");
    check_val("R8 no config", {24'd0, status}, 32'h25);
    drive(1, 3'd4, 0, 0, 0, 0, 0, 1); tick("R8 wakeup");
    check_val("R8 exit request", {24'd0, status}, 32'h27);
    drive(0, 3'd0, 0, 0, 0, 1, 0, 0); tick("R8 exit ack");
    check_val("R8 access", {24'd0, status}, 32'h03);
    for (int c = 5; c < 8; c++) begin
      drive(1, 3'(c), 0, 0, 0, 0, 0, 0); tick("R10 unused code");
      check_val("R10 unused code", {24'd0, status}, 32'h03);
    end

    hr_r = 1'b0;
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(9, 0) < 2) hr_r = ~hr_r;
      drive($urandom_range(1, 0) == 1, 3'($urandom_range(7, 0)),
            $urandom_range(2, 0) == 0, $urandom_range(2, 0) == 0,
            $urandom_range(2, 0) == 0, $urandom_range(2, 0) == 0,
            $urandom_range(3, 0) != 0, hr_r);
      tick("R2 random sequence");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule